// File: doc/BRIEF.md
# Low-Power Mode Wakeup Controller

This block puts a processor core into one of three low-power modes and brings it back out. After halting, the core names the mode it wants: wait, doze or stop. The controller then drops the core clock enable. In stop mode it also drops the bus clock enable. While the core sleeps, a combinational path compares the highest pending interrupt level against a programmed threshold. This path does not depend on the gated core clock.

Wakeup needs a level strictly above the threshold. Which interrupt sources count depends on the mode. In stop mode only the fixed external sources count. In wait and doze modes the programmable sources also count, but only while they are flagged as enabled for low-power operation. Stop mode can be entered only when the stop-enable bit of the control register is set. Otherwise a stop request leaves every clock running.

Leaving a low-power mode follows a fixed order. A single-cycle exit request comes first, in the same cycle in which the clocks come back on. In the following cycle the core is allowed to service the pending interrupt.

Top module: `lpm_wake_ctrl`

## Requirements
- R1: After reset the mode output `lp_mode` is 2'b00 (running). `core_clk_en`, `bus_clk_en` and `irq_service_en` are 1, `exit_req` is 0, and `reg_rdata` reads 8'h00.
- R2: The control register holds the stop enable at bit 7 and a 3-bit wake threshold at bits 6:4. Both read back exactly as written. Bits 3:0 always read zero, and writes to them are ignored.
- R3: The mode request encoding is 2'b00 run, 2'b01 wait, 2'b10 doze and 2'b11 stop. A non-run request is taken on a clock edge only when `core_halted` is 1. `core_clk_en` is then 0 from the next cycle on, and `lp_mode` shows the mode. A request without `core_halted` has no effect.
- R4: A stop request while the stop enable is 0 keeps both clock enables at 1 and `lp_mode` at 2'b00. With the stop enable at 1, stop clears both clock enables.
- R5: In wait and doze modes `bus_clk_en` stays 1. It is 0 only in stop mode.
- R6: A wake requires a level strictly greater than the threshold. A level equal to the threshold does not wake the core.
- R7: In stop mode only `irq_fixed_lvl` counts toward wakeup. `irq_prog_lvl` is ignored there.
- R8: In wait and doze modes the effective level is the larger of `irq_fixed_lvl` and `irq_prog_lvl`. `irq_prog_lvl` counts only while `irq_prog_lp_en` is 1.
- R9: `exit_req` is a single-cycle pulse on the first cycle after the wake edge. In that cycle `core_clk_en` is 1 again, `lp_mode` is 2'b00 and `irq_service_en` is still 0. `irq_service_en` rises in the following cycle. It stays 0 for the whole time the core sleeps.
- R10: `wake_hit` responds combinationally, in the same cycle, to the interrupt levels while asleep. It is 0 while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| core_halted | input | 1 | Core has halted and presents a mode request |
| mode_req | input | 2 | Requested mode (00 run, 01 wait, 10 doze, 11 stop) |
| irq_fixed_lvl | input | 3 | Highest pending fixed-source interrupt level (0 = none) |
| irq_prog_lvl | input | 3 | Highest pending programmable-source interrupt level |
| irq_prog_lp_en | input | 1 | Programmable source is enabled in low-power modes |
| wake_hit | output | 1 | Combinational wake condition while asleep |
| core_clk_en | output | 1 | Core clock enable |
| bus_clk_en | output | 1 | Bus clock enable (dropped in stop only) |
| exit_req | output | 1 | Exit-low-power pulse |
| irq_service_en | output | 1 | Core may service interrupts |
| lp_mode | output | 2 | Current mode, same encoding as `mode_req` |

## Verification
Suppose the state register holds the wrong mode. Then the clock enables, or `lp_mode`, differ at the ports one cycle after the entry edge. A stuck sleep state shows as `exit_req` never pulsing one edge after `wake_hit` rises. A wrong source selection or compare direction is visible on `wake_hit` in the very cycle the levels are applied. Corrupted threshold storage appears on the next register read.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'b00,
        MODE_WAIT = 2'b01,
        MODE_DOZE = 2'b10,
        MODE_STOP = 2'b11
    } lp_mode_e;

    typedef enum logic [1:0] {
        ST_RUN   = 2'b00,
        ST_SLEEP = 2'b01,
        ST_WAKE  = 2'b10
    } fsm_st_e;

endpackage

// File: rtl/lpm_ctrl_reg.sv
module lpm_ctrl_reg #(
    parameter int REG_W = 8,
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic             stop_en,
    output logic [LVL_W-1:0] thr
);
    localparam int STOP_BIT = REG_W - 1;
    localparam int THR_MSB  = STOP_BIT - 1;
    localparam int THR_LSB  = STOP_BIT - LVL_W;

    typedef struct packed {
        logic             stop_en;
        logic [LVL_W-1:0] thr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            ctl_d.stop_en = wdata[STOP_BIT];
            ctl_d.thr     = wdata[THR_MSB:THR_LSB];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        rdata                   = '0;
        rdata[STOP_BIT]         = ctl_q.stop_en;
        rdata[THR_MSB:THR_LSB]  = ctl_q.thr;
    end

    assign stop_en = ctl_q.stop_en;
    assign thr     = ctl_q.thr;

    // R2: written fields read back on the next cycle
    a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rdata[STOP_BIT:THR_LSB] == $past(wdata[STOP_BIT:THR_LSB]));

    // R2: without a write the register holds
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && $past(rst_n)) |=> $stable(rdata));

endmodule

// File: rtl/lpm_wake_eval.sv
module lpm_wake_eval #(
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             asleep,
    input  logic             in_stop,
    input  logic [LVL_W-1:0] thr,
    input  logic [LVL_W-1:0] fixed_lvl,
    input  logic [LVL_W-1:0] prog_lvl,
    input  logic             prog_lp_en,
    output logic             wake_hit
);
    logic [LVL_W-1:0] prog_eff;
    logic [LVL_W-1:0] eff_lvl;

    always_comb begin
        prog_eff = (prog_lp_en && !in_stop) ? prog_lvl : '0;
        eff_lvl  = (prog_eff > fixed_lvl) ? prog_eff : fixed_lvl;
        wake_hit = asleep && (eff_lvl > thr);
    end

    // R7: in stop, a fixed level at or below threshold never wakes
    a_r7_stop_fixed_only: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && in_stop && fixed_lvl <= thr) |-> !wake_hit);

    // R6: equal level does not wake
    a_r6_equal_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (fixed_lvl == thr && (prog_lvl <= thr || !prog_lp_en)) |-> !wake_hit);

    // R10: no wake indication while running
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !asleep |-> !wake_hit);

endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       core_halted,
    input  logic [1:0] mode_req,
    input  logic       stop_en,
    input  logic       wake_hit,
    output logic       asleep,
    output logic       in_stop,
    output logic       core_clk_en,
    output logic       bus_clk_en,
    output logic       exit_req,
    output logic       service_en,
    output logic [1:0] lp_mode
);
    typedef struct packed {
        fsm_st_e  st;
        lp_mode_e mode;
    } fsm_t;

    fsm_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_RUN: begin
                if (core_halted && mode_req != MODE_RUN) begin
                    if (mode_req != MODE_STOP || stop_en) begin
                        s_d.st   = ST_SLEEP;
                        s_d.mode = lp_mode_e'(mode_req);
                    end
                end
            end
            ST_SLEEP: begin
                if (wake_hit) begin
                    s_d.st   = ST_WAKE;
                    s_d.mode = MODE_RUN;
                end
            end
            ST_WAKE: s_d.st = ST_RUN;
            default: begin
                s_d.st   = ST_RUN;
                s_d.mode = MODE_RUN;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st   <= ST_RUN;
            s_q.mode <= MODE_RUN;
        end else begin
            s_q <= s_d;
        end
    end

    assign asleep      = (s_q.st == ST_SLEEP);
    assign in_stop     = asleep && (s_q.mode == MODE_STOP);
    assign core_clk_en = !asleep;
    assign bus_clk_en  = !in_stop;
    assign exit_req    = (s_q.st == ST_WAKE);
    assign service_en  = (s_q.st == ST_RUN);
    assign lp_mode     = s_q.mode;

    // R9: exit request lasts one cycle
    a_r9_exit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        exit_req |=> !exit_req);

    // R9: clocks back on with the pulse, servicing not yet allowed
    a_r9_exit_with_clk: assert property (@(posedge clk) disable iff (!rst_n)
        exit_req |-> (core_clk_en && !service_en));

    // R9: servicing follows the pulse
    a_r9_service_next: assert property (@(posedge clk) disable iff (!rst_n)
        exit_req |=> service_en);

    // R6: the pulse is caused by a wake condition
    a_r6_wake_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exit_req) |-> $past(wake_hit));

    // R4: a stop request with stop disabled keeps the core clock
    a_r4_stop_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (service_en && core_halted && mode_req == 2'b11 && !stop_en) |=> core_clk_en);

    // R5: bus clock runs in wait and doze
    a_r5_bus_clk: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_clk_en && lp_mode != 2'b11) |-> bus_clk_en);

endmodule

// File: rtl/lpm_wake_ctrl.sv
module lpm_wake_ctrl #(
    parameter int REG_W = 8,
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             core_halted,
    input  logic [1:0]       mode_req,
    input  logic [LVL_W-1:0] irq_fixed_lvl,
    input  logic [LVL_W-1:0] irq_prog_lvl,
    input  logic             irq_prog_lp_en,
    output logic             wake_hit,
    output logic             core_clk_en,
    output logic             bus_clk_en,
    output logic             exit_req,
    output logic             irq_service_en,
    output logic [1:0]       lp_mode
);
    logic             stop_en;
    logic [LVL_W-1:0] thr;
    logic             asleep;
    logic             in_stop;

    lpm_ctrl_reg #(.REG_W(REG_W), .LVL_W(LVL_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .stop_en (stop_en),
        .thr     (thr)
    );

    lpm_wake_eval #(.LVL_W(LVL_W)) u_eval (
        .clk        (clk),
        .rst_n      (rst_n),
        .asleep     (asleep),
        .in_stop    (in_stop),
        .thr        (thr),
        .fixed_lvl  (irq_fixed_lvl),
        .prog_lvl   (irq_prog_lvl),
        .prog_lp_en (irq_prog_lp_en),
        .wake_hit   (wake_hit)
    );

    lpm_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .core_halted (core_halted),
        .mode_req    (mode_req),
        .stop_en     (stop_en),
        .wake_hit    (wake_hit),
        .asleep      (asleep),
        .in_stop     (in_stop),
        .core_clk_en (core_clk_en),
        .bus_clk_en  (bus_clk_en),
        .exit_req    (exit_req),
        .service_en  (irq_service_en),
        .lp_mode     (lp_mode)
    );

endmodule

// File: tb/lpm_wake_ctrl_tb.sv
module lpm_wake_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_wr_en;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       core_halted;
    logic [1:0] mode_req;
    logic [2:0] irq_fixed_lvl;
    logic [2:0] irq_prog_lvl;
    logic       irq_prog_lp_en;
    logic       wake_hit, core_clk_en, bus_clk_en, exit_req, irq_service_en;
    logic [1:0] lp_mode;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    lpm_wake_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .core_halted(core_halted), .mode_req(mode_req),
        .irq_fixed_lvl(irq_fixed_lvl), .irq_prog_lvl(irq_prog_lvl),
        .irq_prog_lp_en(irq_prog_lp_en), .wake_hit(wake_hit),
        .core_clk_en(core_clk_en), .bus_clk_en(bus_clk_en), .exit_req(exit_req),
        .irq_service_en(irq_service_en), .lp_mode(lp_mode)
    );

    // mode, stop_en, thr, fixed, prog, prog_en, expected wake
    localparam logic [13:0] VEC [12] = '{
        {2'd1, 1'b0, 3'd3, 3'd4, 3'd0, 1'b0, 1'b1},
        {2'd1, 1'b0, 3'd3, 3'd3, 3'd0, 1'b0, 1'b0},
        {2'd1, 1'b0, 3'd3, 3'd0, 3'd5, 1'b1, 1'b1},
        {2'd1, 1'b0, 3'd3, 3'd0, 3'd5, 1'b0, 1'b0},
        {2'd2, 1'b0, 3'd2, 3'd0, 3'd3, 1'b1, 1'b1},
        {2'd2, 1'b0, 3'd2, 3'd2, 3'd2, 1'b1, 1'b0},
        {2'd3, 1'b1, 3'd1, 3'd0, 3'd6, 1'b1, 1'b0},
        {2'd3, 1'b1, 3'd1, 3'd2, 3'd0, 1'b0, 1'b1},
        {2'd3, 1'b1, 3'd4, 3'd4, 3'd7, 1'b1, 1'b0},
        {2'd2, 1'b0, 3'd0, 3'd1, 3'd0, 1'b0, 1'b1},
        {2'd1, 1'b0, 3'd6, 3'd0, 3'd7, 1'b1, 1'b1},
        {2'd3, 1'b1, 3'd6, 3'd7, 3'd0, 1'b0, 1'b1}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_reg(input logic [7:0] v);
        reg_wr_en = 1'b1;
        reg_wdata = v;
        tick();
        reg_wr_en = 1'b0;
    endtask

    task automatic enter(input logic [1:0] m);
        core_halted = 1'b1;
        mode_req    = m;
        tick();
        core_halted = 1'b0;
        mode_req    = 2'b00;
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_wr_en = 1'b0; reg_wdata = '0; core_halted = 1'b0;
        mode_req = 2'b00; irq_fixed_lvl = '0; irq_prog_lvl = '0; irq_prog_lp_en = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check(lp_mode == 2'b00, "R1 lp_mode", lp_mode, 0);
        check(core_clk_en && bus_clk_en, "R1 clk_en", {core_clk_en, bus_clk_en}, 3);
        check(irq_service_en && !exit_req, "R1 service/exit", {irq_service_en, exit_req}, 2);
        check(reg_rdata == 8'h00, "R1 rdata", reg_rdata, 0);

        // R2 readback and reserved bits
        wr_reg(8'hFF);
        check(reg_rdata == 8'hF0, "R2 reserved ignored", reg_rdata, 8'hF0);
        wr_reg(8'h5A);
        check(reg_rdata == 8'h50, "R2 readback", reg_rdata, 8'h50);

        // R4 stop blocked when stop enable is 0
        wr_reg(8'h30);
        enter(2'b11);
        check(core_clk_en && bus_clk_en, "R4 stop blocked clocks", {core_clk_en, bus_clk_en}, 3);
        check(lp_mode == 2'b00, "R4 stop blocked mode", lp_mode, 0);

        // R3 request without halted is ignored
        mode_req = 2'b01;
        tick();
        mode_req = 2'b00;
        check(core_clk_en && lp_mode == 2'b00, "R3 no halt no entry", lp_mode, 0);

        // R10 wake_hit quiet while running
        irq_fixed_lvl = 3'd7;
        #1;
        check(!wake_hit, "R10 quiet in run", wake_hit, 0);
        irq_fixed_lvl = '0;

        foreach (VEC[i]) begin
            logic [1:0] m;
            logic       se, pe, ex;
            logic [2:0] th, fx, pg;
            {m, se, th, fx, pg, pe, ex} = VEC[i];
            wr_reg({se, th, 4'h0});
            enter(m);
            check(!core_clk_en, "R3 core clk off", core_clk_en, 0);
            check(lp_mode == m, "R3 lp_mode", lp_mode, m);
            check(bus_clk_en == (m != 2'b11), "R5 bus clk", bus_clk_en, m != 2'b11);
            check(!irq_service_en, "R9 no service asleep", irq_service_en, 0);
            irq_fixed_lvl  = fx;
            irq_prog_lvl   = pg;
            irq_prog_lp_en = pe;
            #1;
            check(wake_hit == ex, (m == 2'b11) ? "R7 stop wake" : "R8 wait/doze wake", wake_hit, ex);
            tick();
            check(exit_req == ex, "R6 exit on compare", exit_req, ex);
            check(core_clk_en == ex, "R9 clk with exit", core_clk_en, ex);
            if (!ex) begin
                irq_fixed_lvl = 3'd7;
                irq_prog_lvl  = '0;
                tick();
                check(exit_req, "R7 fixed wake recovers", exit_req, 1);
            end
            check(lp_mode == 2'b00 && !irq_service_en, "R9 pulse cycle", irq_service_en, 0);
            irq_fixed_lvl = '0; irq_prog_lvl = '0; irq_prog_lp_en = 1'b0;
            tick();
            check(!exit_req && irq_service_en, "R9 single pulse then service",
                  {exit_req, irq_service_en}, 1);
        end

        // R6 boundary: threshold 7 never wakes
        wr_reg(8'h70);
        enter(2'b01);
        irq_fixed_lvl = 3'd7;
        #1;
        check(!wake_hit, "R6 level equal to max threshold", wake_hit, 0);
        tick();
        check(!exit_req && !core_clk_en, "R6 stays asleep", exit_req, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule